// File: doc/BRIEF.md
# Signed Range Clamp with Flag

This block accepts a single 32-bit word carrying three signed 8-bit quantities, a lower limit, an upper limit and a candidate value, and reduces them to a clamped 32-bit result and a one-bit out-of-range flag. A candidate that falls inside the inclusive window passes through unchanged. A candidate outside the window is replaced by the limit it crossed, and the flag goes high. Every result leaves the block sign-extended to the full 32 bits.

The decision logic is purely combinational. An output stage, selected by a parameter, either registers the result and flag on clock edges where `in_valid` is high, or passes them straight through. The default is the registered stage. Callers must supply a well-formed window, with the lower limit no greater than the upper limit. The result is not defined when the lower limit is above the upper limit.

Top module: `range_clamp`

## Requirements
- R1: Field positions in `in_word` are fixed: bits [7:0] hold the lower limit, bits [15:8] hold the upper limit and bits [31:24] hold the candidate.
- R2: Bits [23:16] of `in_word` have no effect on `out_result` or `out_flag`.
- R3: All three fields are compared as signed two's-complement 8-bit numbers. `out_result` is always the selected field sign-extended, so bits [31:8] all equal bit 7.
- R4: When lower <= candidate <= upper, `out_result` is the candidate and `out_flag` is 0. This includes a candidate equal to either limit.
- R5: When the candidate is below the lower limit, `out_result` is the lower limit and `out_flag` is 1.
- R6: When the candidate is above the upper limit, `out_result` is the upper limit and `out_flag` is 1.
- R7: In the registered variant, `out_result` and `out_flag` are captured on a rising edge where `in_valid` is 1. `out_valid` is 1 in the cycle after that edge and 0 after an edge where `in_valid` is 0.
- R8: After an edge where `in_valid` is 0, `out_result` and `out_flag` keep their previous values, whatever `in_word` holds.
- R9: A synchronous active-high `rst` clears `out_valid`, `out_result` and `out_flag` to 0, and takes priority over `in_valid`.
- R10: Input 0xcc0010ab yields result 0xffffffcc with flag 0. Input 0x66ff5544 yields result 0x00000055 with flag 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_word` for capture |
| in_word | input | 32 | Packed candidate, upper limit and lower limit |
| out_result | output | 32 | Clamped value, sign-extended |
| out_flag | output | 1 | High when the candidate was out of range |
| out_valid | output | 1 | High for the cycle after a captured input |

## Verification
In the default variant, both `out_result` and `out_flag` are due exactly one rising edge after the edge that samples `in_valid`, and `out_valid` follows on the same edge. The bench drives each vector on a falling edge and samples the outputs on the next falling edge, so exactly one rising edge lies between drive and check. The hold and reset checks use the same spacing, which lets a late or early update show up as a mismatch. Assertions restate the same one-cycle relation from the sampled input fields.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int unsigned FIELD_W  = 8;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned LO_POS   = 0;
  localparam int unsigned HI_POS   = 8;
  localparam int unsigned CAND_POS = 24;
  localparam int unsigned EXT_W    = WORD_W - FIELD_W;

  typedef logic signed [FIELD_W-1:0] field_t;
  typedef logic [WORD_W-1:0]         word_t;

  typedef struct packed {
    field_t cand;
    field_t hi;
    field_t lo;
  } fields_t;

  typedef enum logic [1:0] {
    PICK_CAND = 2'd0,
    PICK_LO   = 2'd1,
    PICK_HI   = 2'd2
  } pick_e;

  // slice one signed field out of the packed word
  function automatic field_t take_field(word_t w, int unsigned pos);
    return field_t'(w[pos +: FIELD_W]);
  endfunction

  // replicate the field sign into the upper bits
  function automatic word_t sext(field_t v);
    return {{EXT_W{v[FIELD_W-1]}}, v};
  endfunction

  function automatic logic less_s(field_t a, field_t b);
    return a < b;
  endfunction
endpackage

// File: rtl/rc_unpack.sv
module rc_unpack
  import rc_pkg::*;
(
  input  word_t   word,
  output fields_t fields
);
  always_comb begin
    fields.lo   = take_field(word, LO_POS);
    fields.hi   = take_field(word, HI_POS);
    fields.cand = take_field(word, CAND_POS);
  end
endmodule

// File: rtl/rc_judge.sv
module rc_judge
  import rc_pkg::*;
(
  input  fields_t fields,
  output word_t   result,
  output logic    under,
  output logic    over
);
  pick_e  pick;
  field_t chosen;

  always_comb begin
    under = less_s(fields.cand, fields.lo);
    over  = less_s(fields.hi, fields.cand);
    if (under)     pick = PICK_LO;
    else if (over) pick = PICK_HI;
    else           pick = PICK_CAND;
    case (pick)
      PICK_LO: chosen = fields.lo;
      PICK_HI: chosen = fields.hi;
      default: chosen = fields.cand;
    endcase
    result = sext(chosen);
  end
endmodule

// File: rtl/rc_outstage.sv
module rc_outstage
  import rc_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  d_valid,
  input  word_t d_result,
  input  logic  d_flag,
  output word_t q_result,
  output logic  q_flag,
  output logic  q_valid
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          q_result <= '0;
          q_flag   <= 1'b0;
          q_valid  <= 1'b0;
        end else begin
          q_valid <= d_valid;
          if (d_valid) begin
            q_result <= d_result;
            q_flag   <= d_flag;
          end
        end
      end
    end else begin : g_thru
      assign q_result = d_result;
      assign q_flag   = d_flag;
      assign q_valid  = d_valid;
    end
  endgenerate
endmodule

// File: rtl/range_clamp.sv
module range_clamp
  import rc_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [31:0] in_word,
  output logic [31:0] out_result,
  output logic        out_flag,
  output logic        out_valid
);
  fields_t fields;
  word_t   comb_result;
  logic    viol_low;
  logic    viol_high;
  logic    comb_flag;

  rc_unpack u_unpack (
    .word   (in_word),
    .fields (fields)
  );

  rc_judge u_judge (
    .fields (fields),
    .result (comb_result),
    .under  (viol_low),
    .over   (viol_high)
  );

  assign comb_flag = viol_low | viol_high;

  rc_outstage #(.REG_OUT(REG_OUT)) u_out (
    .clk      (clk),
    .rst      (rst),
    .d_valid  (in_valid),
    .d_result (comb_result),
    .d_flag   (comb_flag),
    .q_result (out_result),
    .q_flag   (out_flag),
    .q_valid  (out_valid)
  );
endmodule

// File: rtl/range_clamp_chk.sv
module range_clamp_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [7:0]  lo_b,
  input logic [7:0]  hi_b,
  input logic [7:0]  cand_b,
  input logic [31:0] out_result,
  input logic        out_flag,
  input logic        out_valid,
  input logic        viol_low,
  input logic        viol_high
);
  generate
    if (REG_OUT) begin : g_chk
      p_sext_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_result[31:8] == {24{out_result[7]}});

      p_valid_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> out_valid == $past(in_valid));

      p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result) && $stable(out_flag));

      p_inside_r4: assert property (@(posedge clk) disable iff (rst)
        in_valid && !viol_low && !viol_high |=>
          !out_flag && out_result[7:0] == $past(cand_b));

      p_below_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid && viol_low |=> out_flag && out_result[7:0] == $past(lo_b));

      p_above_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid && viol_high && !viol_low |=>
          out_flag && out_result[7:0] == $past(hi_b));
    end
  endgenerate
endmodule

bind range_clamp range_clamp_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .lo_b       (in_word[7:0]),
  .hi_b       (in_word[15:8]),
  .cand_b     (in_word[31:24]),
  .out_result (out_result),
  .out_flag   (out_flag),
  .out_valid  (out_valid),
  .viol_low   (viol_low),
  .viol_high  (viol_high)
);

// File: tb/range_clamp_tb.sv
`timescale 1ns/1ps
module range_clamp_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic [31:0] out_result;
  logic        out_flag;
  logic        out_valid;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  range_clamp u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .out_result(out_result), .out_flag(out_flag), .out_valid(out_valid)
  );

  function automatic logic [31:0] pack(int lo, int hi, int cand, int pad);
    logic [7:0] a, b, c, d;
    a = 8'(lo); b = 8'(hi); c = 8'(cand); d = 8'(pad);
    return {c, d, b, a};
  endfunction

  // independent model: integer arithmetic on the decoded fields
  task automatic model(input logic [31:0] w, output logic [31:0] r, output logic f);
    int lo, hi, c, v;
    lo = int'($signed(w[7:0]));
    hi = int'($signed(w[15:8]));
    c  = int'($signed(w[31:24]));
    f  = (c < lo) || (c > hi);
    v  = (c < lo) ? lo : ((c > hi) ? hi : c);
    r  = 32'(v);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one vector, check after the next rising edge
  task automatic apply(input string req, input logic [31:0] w);
    logic [31:0] er;
    logic ef;
    model(w, er, ef);
    @(negedge clk);
    in_word = w; in_valid = 1'b1;
    @(negedge clk);
    chk(req, out_result, er);
    chk(req, {31'b0, out_flag}, {31'b0, ef});
    chk({req, " R7 valid"}, {31'b0, out_valid}, 32'd1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_word = 32'h7f80_00ff;
    @(negedge clk);
    chk("R9 valid", {31'b0, out_valid}, 32'd0);
    chk("R9 result", out_result, 32'd0);
    chk("R9 flag", {31'b0, out_flag}, 32'd0);
    rst = 1'b0; in_valid = 1'b0;
  endtask

  task automatic t_examples();
    apply("R10 R1 in-range example", 32'hcc0010ab);
    chk("R10 literal", out_result, 32'hffffffcc);
    apply("R10 R1 above example", 32'h66ff5544);
    chk("R10 literal", out_result, 32'h00000055);
    chk("R10 flag", {31'b0, out_flag}, 32'd1);
  endtask

  task automatic t_edges();
    apply("R4 equal lower", pack(-5, 9, -5, 0));
    apply("R4 equal upper", pack(-5, 9, 9, 0));
    apply("R4 single point", pack(-128, -128, -128, 3));
    apply("R5 below min", pack(-127, 127, -128, 0));
    apply("R6 above max", pack(-128, 126, 127, 0));
    apply("R3 negative window", pack(-100, -20, -10, 0));
    apply("R3 sign of 0x80", pack(-128, 0, -128, 0));
  endtask

  task automatic t_pad();
    logic [31:0] first;
    logic        ff;
    apply("R2 pad 00", pack(-3, 40, 77, 8'h00));
    first = out_result; ff = out_flag;
    apply("R2 pad ff", pack(-3, 40, 77, 8'hff));
    chk("R2 result", out_result, first);
    chk("R2 flag", {31'b0, out_flag}, {31'b0, ff});
  endtask

  task automatic t_hold();
    logic [31:0] keep;
    logic        kf;
    apply("R8 seed", pack(10, 20, 30, 0));
    keep = out_result; kf = out_flag;
    @(negedge clk);
    in_valid = 1'b0; in_word = pack(-50, -40, 0, 0);
    @(negedge clk);
    chk("R8 result", out_result, keep);
    chk("R8 flag", {31'b0, out_flag}, {31'b0, kf});
    chk("R7 idle valid", {31'b0, out_valid}, 32'd0);
  endtask

  task automatic t_sweep();
    for (int lo = -128; lo <= 127; lo += 5)
      for (int hi = lo; hi <= 127; hi += 9)
        for (int c = -128; c <= 127; c += 3)
          apply("R4 R5 R6 sweep", pack(lo, hi, c, int'($urandom_range(255))));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 after reset", {31'b0, out_valid}, 32'd0);
    t_examples();
    t_edges();
    t_pad();
    t_hold();
    t_reset();
    t_sweep();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule